// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Completion

This block collects up to 80 level-sensitive interrupt requests for a single processor and raises one interrupt line toward it. Each request sets a sticky pending bit. Software assigns each source a small priority and an enable bit, and sets one global threshold. The block then selects the most urgent source that is pending, enabled and above the threshold, and it drives the interrupt line from that selection.

Software services an interrupt in two register steps. A read of the claim register returns the selected source number. The same read clears that source's pending bit and marks the source as in service. While a source is in service, its request line cannot set the pending bit again. Software writes the same number back to the claim register when the handler is done, and the source can then pend again. Number 0 means "no interrupt", and source 0 is never selectable.

The register port is a plain 32-bit read/write bus with byte enables. Read data returns one cycle after the request.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the priorities, enables, threshold, pending bits and in-service bits are all zero, and `irq_o` and `bus_rvalid` are low.
- R2: While source n (n ≥ 1) is requested and not in service, its pending bit is set at the next clock. The bit is readable at byte offset 0x000 + 4·(n/32), bit n%32. A request on source 0 never sets anything.
- R3: The pending words are read-only, and writing them changes nothing. The three words at 0x00C–0x014 and any unmapped aligned offset read as zero and ignore writes. A pending bit is cleared only by a claim read.
- R4: The priority of source n (1..79) is at 0x018 + 4·(n−1) and keeps only bits [2:0] of a write. The threshold at 0x20C keeps only bits [1:0].
- R5: The enable of source n is bit n%32 of the word at 0x200 + 4·(n/32). Bits that belong to no source (source 0, sources 80 and above) read as zero.
- R6: `irq_o` is high, one clock after the state that causes it, exactly when some source is pending, enabled and has a priority strictly greater than the threshold.
- R7: A read of 0x210 returns the number of the eligible source with the highest priority. When priorities are equal, the lower source number wins.
- R8: That claim read clears the returned source's pending bit and puts the source in service. A source in service never has its pending bit set, even while its request stays high.
- R9: Writing a source number to 0x210 takes that source out of service. A request that is still high then pends it again.
- R10: A claim read with no eligible source returns 0 and changes no state.
- R11: An access whose byte enables are not all four set, or whose address is not word-aligned, has no effect. Such a read returns zero and does not claim.
- R12: Every read request is answered one clock later with `bus_rvalid` high and the data on `bus_rdata`. A write request leaves `bus_rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 80 | Level interrupt requests, bit n is source n |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_addr | input | 10 | Byte offset inside the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| irq_o | output | 1 | Registered external interrupt to the core |

## Verification
The assertions check several invariants on every cycle. A source is never pending and in service at once, and source 0 stays idle. A pending bit falls only after a claim read. A raised `irq_o` always has a pending, enabled source behind it. At most one source enters service per cycle, an empty claim leaves the in-service set untouched, and every read gets its valid strobe. Some behaviour only the bench's scenarios can show: the priority order and the tie-breaking among sources, the exact threshold comparison, the register field masking and map layout, the re-pending after completion, and the rejection of partial or misaligned accesses.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned SRC_CNT   = 80;
    localparam int unsigned PRIO_BITS = 3;
    localparam int unsigned THR_BITS  = 2;
    localparam int unsigned ADDR_BITS = 10;
    localparam int unsigned DATA_BITS = 32;
    localparam int unsigned IDX_W     = 8;

    // Word offsets (byte offset / 4) of each register region
    localparam int unsigned WOFS_PEND  = 32'h000 >> 2;
    localparam int unsigned WOFS_MODE  = 32'h00C >> 2;
    localparam int unsigned WOFS_PRIO  = 32'h018 >> 2;
    localparam int unsigned WOFS_ENAB  = 32'h200 >> 2;
    localparam int unsigned WOFS_THR   = 32'h20C >> 2;
    localparam int unsigned WOFS_CLAIM = 32'h210 >> 2;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_PEND,
        RGN_MODE,
        RGN_PRIO,
        RGN_ENAB,
        RGN_THR,
        RGN_CLAIM
    } region_e;

    typedef struct packed {
        region_e            rgn;
        logic [IDX_W-1:0]   idx;
    } decode_t;

    // Map a byte offset to a region and an index inside it.
    // For priorities the index is the source number itself.
    function automatic decode_t decode_addr(
        input logic [ADDR_BITS-1:0] addr,
        input int unsigned          words,
        input int unsigned          srcs
    );
        decode_t     d;
        int unsigned w;
        d.rgn = RGN_NONE;
        d.idx = '0;
        w     = int'(addr[ADDR_BITS-1:2]);
        if (addr[1:0] == 2'b00) begin
            if (w >= WOFS_PEND && w < WOFS_PEND + words) begin
                d.rgn = RGN_PEND;
                d.idx = IDX_W'(w - WOFS_PEND);
            end else if (w >= WOFS_MODE && w < WOFS_MODE + words) begin
                d.rgn = RGN_MODE;
            end else if (w >= WOFS_PRIO && w < WOFS_PRIO + srcs - 1) begin
                d.rgn = RGN_PRIO;
                d.idx = IDX_W'(w - WOFS_PRIO + 1);
            end else if (w >= WOFS_ENAB && w < WOFS_ENAB + words) begin
                d.rgn = RGN_ENAB;
                d.idx = IDX_W'(w - WOFS_ENAB);
            end else if (w == WOFS_THR) begin
                d.rgn = RGN_THR;
            end else if (w == WOFS_CLAIM) begin
                d.rgn = RGN_CLAIM;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_ctrl_gate.sv
// Per-source pending / in-service state.
module irq_ctrl_gate #(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned ID_W    = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               take_i,
    input  logic [ID_W-1:0]    take_id_i,
    input  logic               done_i,
    input  logic [ID_W-1:0]    done_id_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] clm_o
);

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        if (n == 0) begin : g_null
            logic unused_req;
            assign unused_req = src_i[n];
            assign pend_o[n]  = 1'b0;
            assign clm_o[n]   = 1'b0;
        end else begin : g_live
            logic pend_q;
            logic clm_q;
            logic take;
            logic done;

            assign take = take_i && (take_id_i == ID_W'(n));
            assign done = done_i && (done_id_i == ID_W'(n));

            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q <= 1'b0;
                    clm_q  <= 1'b0;
                end else begin
                    // request latches only while not in service; claim clears
                    pend_q <= (pend_q | (src_i[n] & ~clm_q)) & ~take;
                    clm_q  <= (clm_q & ~done) | take;
                end
            end

            assign pend_o[n] = pend_q;
            assign clm_o[n]  = clm_q;
        end
    end

endmodule

// File: rtl/irq_ctrl_cfg.sv
// Software-visible configuration: priorities, enables, threshold.
module irq_ctrl_cfg
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned THR_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_i,
    input  region_e                         rgn_i,
    input  logic [IDX_W-1:0]                idx_i,
    input  logic [31:0]                     wdata_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [NUM_SRC-1:0]              en_o,
    output logic [THR_W-1:0]                thr_o
);

    logic [THR_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (wr_i && rgn_i == RGN_THR) begin
            thr_q <= wdata_i[THR_W-1:0];
        end
    end
    assign thr_o = thr_q;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_cfg
        if (n == 0) begin : g_null
            assign prio_o[n] = '0;
            assign en_o[n]   = 1'b0;
        end else begin : g_live
            logic [PRIO_W-1:0] prio_q;
            logic              en_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    prio_q <= '0;
                    en_q   <= 1'b0;
                end else if (wr_i) begin
                    if (rgn_i == RGN_PRIO && idx_i == IDX_W'(n))
                        prio_q <= wdata_i[PRIO_W-1:0];
                    if (rgn_i == RGN_ENAB && idx_i == IDX_W'(n / 32))
                        en_q <= wdata_i[n % 32];
                end
            end

            assign prio_o[n] = prio_q;
            assign en_o[n]   = en_q;
        end
    end

endmodule

// File: rtl/irq_ctrl_arb.sv
// Combinational selection of the most urgent eligible source.
module irq_ctrl_arb #(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned THR_W   = 2,
    parameter int unsigned ID_W    = 7
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [THR_W-1:0]               thr_i,
    output logic [ID_W-1:0]                best_id_o,
    output logic                           hit_o
);

    logic [NUM_SRC-1:0] elig;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_elig
        assign elig[n] = pend_i[n] & en_i[n];
    end

    always_comb begin
        logic [PRIO_W-1:0] bar;
        bar       = PRIO_W'(thr_i);
        best_id_o = '0;
        hit_o     = 1'b0;
        // strict compare keeps the lowest number on a tie
        for (int n = 1; n < NUM_SRC; n++) begin
            if (elig[n] && prio_i[n] > bar) begin
                bar       = prio_i[n];
                best_id_o = ID_W'(n);
                hit_o     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_CNT,
    parameter int unsigned PRIO_W  = PRIO_BITS,
    parameter int unsigned THR_W   = THR_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [3:0]           bus_be,
    input  logic [ADDR_BITS-1:0] bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic                 irq_o
);

    localparam int unsigned WORDS = (NUM_SRC + 31) / 32;
    localparam int unsigned PAD_W = WORDS * 32;
    localparam int unsigned ID_W  = $clog2(NUM_SRC);

    decode_t                       dec;
    logic                          acc_ok;
    logic                          wr;
    logic                          rd;
    logic                          claim_rd;
    logic                          done;
    logic [NUM_SRC-1:0]            pend_vec;
    logic [NUM_SRC-1:0]            clm_vec;
    logic [NUM_SRC-1:0]            en_vec;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
    logic [THR_W-1:0]              thr;
    logic [ID_W-1:0]               sel_id;
    logic                          sel_hit;
    logic [PAD_W-1:0]              pend_pad;
    logic [PAD_W-1:0]              en_pad;
    logic [31:0]                   rd_word;
    logic [31:0]                   rdata_q;
    logic                          rvalid_q;
    logic                          irq_q;

    assign dec      = decode_addr(bus_addr, WORDS, NUM_SRC);
    assign acc_ok   = bus_req && (bus_be == 4'hF);
    assign wr       = acc_ok && bus_we;
    assign rd       = acc_ok && !bus_we;
    assign claim_rd = rd && (dec.rgn == RGN_CLAIM);
    assign done     = wr && (dec.rgn == RGN_CLAIM) && ((bus_wdata >> ID_W) == '0);

    irq_ctrl_gate #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .take_i    (claim_rd && sel_hit),
        .take_id_i (sel_id),
        .done_i    (done),
        .done_id_i (bus_wdata[ID_W-1:0]),
        .pend_o    (pend_vec),
        .clm_o     (clm_vec)
    );

    irq_ctrl_cfg #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .THR_W   (THR_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .rgn_i   (dec.rgn),
        .idx_i   (dec.idx),
        .wdata_i (bus_wdata),
        .prio_o  (prio_vec),
        .en_o    (en_vec),
        .thr_o   (thr)
    );

    irq_ctrl_arb #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .THR_W   (THR_W),
        .ID_W    (ID_W)
    ) u_arb (
        .pend_i    (pend_vec),
        .en_i      (en_vec),
        .prio_i    (prio_vec),
        .thr_i     (thr),
        .best_id_o (sel_id),
        .hit_o     (sel_hit)
    );

    assign pend_pad = PAD_W'(pend_vec);
    assign en_pad   = PAD_W'(en_vec);

    always_comb begin
        rd_word = '0;
        unique case (dec.rgn)
            RGN_PEND:  rd_word = pend_pad[32*int'(dec.idx) +: 32];
            RGN_ENAB:  rd_word = en_pad[32*int'(dec.idx) +: 32];
            RGN_PRIO:  rd_word = 32'(prio_vec[dec.idx[ID_W-1:0]]);
            RGN_THR:   rd_word = 32'(thr);
            RGN_CLAIM: rd_word = 32'(sel_id);
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            rdata_q  <= rd ? rd_word : '0;
            rvalid_q <= bus_req && !bus_we;
            irq_q    <= sel_hit;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign irq_o      = irq_q;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int unsigned NUM_SRC = 80
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_req,
    input logic               bus_we,
    input logic               bus_rvalid,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] clm,
    input logic [NUM_SRC-1:0] en,
    input logic               claim_rd,
    input logic               hit
);

    AST_SERVICE_BLOCKS_PEND: assert property (@(posedge clk) disable iff (rst)
        (pend & clm) == '0); // R8

    AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pend[0] && !clm[0]); // R2

    AST_PEND_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend) & ~pend)) |-> $past(claim_rd)); // R3

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(pend & en))); // R6

    AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (rst)
        $countones(clm & ~$past(clm)) <= 1); // R8

    AST_EMPTY_CLAIM_NOP: assert property (@(posedge clk) disable iff (rst)
        (claim_rd && !hit) |=> $stable(clm)); // R10

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid); // R12

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && !bus_we) |=> !bus_rvalid); // R12

endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid),
    .irq_o      (irq_o),
    .pend       (pend_vec),
    .clm        (clm_vec),
    .en         (en_vec),
    .claim_rd   (claim_rd),
    .hit        (sel_hit)
);

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;
    import irq_ctrl_pkg::*;

    localparam int N = SRC_CNT;

    typedef struct packed {
        logic        we;
        logic [3:0]  be;
        logic [9:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'hF, 10'h018, 32'h0000_00FF},
        '{1'b0, 4'hF, 10'h018, 32'h0000_0007},   // R4 priority mask
        '{1'b1, 4'hF, 10'h20C, 32'h0000_00FF},
        '{1'b0, 4'hF, 10'h20C, 32'h0000_0003},   // R4 threshold mask
        '{1'b1, 4'hF, 10'h204, 32'hA5A5_A5A5},
        '{1'b0, 4'hF, 10'h204, 32'hA5A5_A5A5},   // R5 enable word 1
        '{1'b1, 4'hF, 10'h208, 32'hFFFF_FFFF},
        '{1'b0, 4'hF, 10'h208, 32'h0000_FFFF},   // R5 no bits past source 79
        '{1'b1, 4'hF, 10'h200, 32'hFFFF_FFFF},
        '{1'b0, 4'hF, 10'h200, 32'hFFFF_FFFE},   // R5 source 0 bit reads zero
        '{1'b1, 4'hF, 10'h000, 32'hFFFF_FFFF},
        '{1'b0, 4'hF, 10'h000, 32'h0000_0000},   // R3 pending read-only
        '{1'b1, 4'hF, 10'h010, 32'h0000_1234},
        '{1'b0, 4'hF, 10'h010, 32'h0000_0000},   // R3 mode word reads zero
        '{1'b1, 4'hF, 10'h3F0, 32'h0000_0077},
        '{1'b0, 4'hF, 10'h3F0, 32'h0000_0000},   // R3 unmapped reads zero
        '{1'b1, 4'h3, 10'h01C, 32'h0000_0005},
        '{1'b0, 4'hF, 10'h01C, 32'h0000_0000},   // R11 partial write ignored
        '{1'b1, 4'hF, 10'h01D, 32'h0000_0004},
        '{1'b0, 4'hF, 10'h01C, 32'h0000_0000},   // R11 misaligned write ignored
        '{1'b1, 4'hF, 10'h150, 32'h0000_0006},
        '{1'b0, 4'hF, 10'h150, 32'h0000_0006},   // R4 last source priority
        '{1'b1, 4'hF, 10'h20C, 32'h0000_0000},
        '{1'b1, 4'hF, 10'h200, 32'h0000_0000},
        '{1'b1, 4'hF, 10'h204, 32'h0000_0000},
        '{1'b1, 4'hF, 10'h208, 32'h0000_0000},
        '{1'b1, 4'hF, 10'h018, 32'h0000_0000},
        '{1'b1, 4'hF, 10'h150, 32'h0000_0000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src = '0;
    logic         req = 1'b0;
    logic         we  = 1'b0;
    logic [3:0]   be  = '0;
    logic [9:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         rvalid;
    logic         irq;

    int errs   = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src),
        .bus_req    (req),
        .bus_we     (we),
        .bus_be     (be),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .bus_rvalid (rvalid),
        .irq_o      (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [9:0] a, input logic [31:0] d,
                          input logic [3:0] b, output logic [31:0] r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; be = b;
        @(negedge clk);
        req = 1'b0; we = 1'b0; be = '0;
        r = rdata;
        check("R12 rvalid", 32'(rvalid), w ? 32'd0 : 32'd1);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        access(1'b1, a, d, 4'hF, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] r;
        access(1'b0, a, 32'h0, 4'hF, r);
        check(tag, r, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<20000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 rvalid after reset", 32'(rvalid), 0);
        rd_chk("R1 threshold", 10'h20C, 0);
        rd_chk("R1 enable word 0", 10'h200, 0);
        rd_chk("R1 priority", 10'h018, 0);
        rd_chk("R1 pending", 10'h000, 0);

        // register table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].data, VEC[i].be, r);
            if (!VEC[i].we)
                check($sformatf("table row %0d", i), r, VEC[i].data);
        end

        // R2 pending from requests, source 0 ignored
        src[0] = 1'b1; src[5] = 1'b1; src[40] = 1'b1;
        settle(3);
        rd_chk("R2 pending word 0", 10'h000, 32'h0000_0020);
        rd_chk("R2 pending word 1", 10'h004, 32'h0000_0100);

        // R6 threshold comparison
        wr(10'h200, 32'h0000_0020);
        settle(3);
        check("R6 prio 0 not above thr 0", 32'(irq), 0);
        wr(10'h028, 32'd2);
        wr(10'h20C, 32'd2);
        settle(3);
        check("R6 prio equal to thr", 32'(irq), 0);
        wr(10'h20C, 32'd1);
        settle(3);
        check("R6 prio above thr", 32'(irq), 1);

        // R7 priority order and tie
        wr(10'h0B4, 32'd5);
        wr(10'h0B8, 32'd5);
        src[41] = 1'b1;
        wr(10'h204, 32'h0000_0300);
        settle(3);
        rd_chk("R7 tie lower id wins", 10'h210, 32'd40);
        rd_chk("R8 claim clears pending", 10'h004, 32'h0000_0200);
        settle(3);
        rd_chk("R8 no re-pend while in service", 10'h004, 32'h0000_0200);
        rd_chk("R7 next claim", 10'h210, 32'd41);
        rd_chk("R7 lowest priority last", 10'h210, 32'd5);
        settle(3);
        check("R6 irq drops after claims", 32'(irq), 0);
        rd_chk("R10 empty claim", 10'h210, 32'd0);
        rd_chk("R10 pending word 0 unchanged", 10'h000, 0);
        rd_chk("R10 pending word 1 unchanged", 10'h004, 0);

        // R9 completion
        wr(10'h210, 32'd40);
        settle(3);
        rd_chk("R9 re-pend after completion", 10'h004, 32'h0000_0100);
        check("R9 irq after completion", 32'(irq), 1);

        // R11 partial completion ignored
        access(1'b1, 10'h210, 32'd41, 4'h3, r);
        settle(3);
        rd_chk("R11 partial completion", 10'h004, 32'h0000_0100);
        wr(10'h210, 32'd41);
        settle(3);
        rd_chk("R9 second completion", 10'h004, 32'h0000_0300);

        // R11 partial claim read
        access(1'b0, 10'h210, 32'h0, 4'h1, r);
        check("R11 partial read data", r, 0);
        rd_chk("R11 partial read no claim", 10'h004, 32'h0000_0300);

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        settle(2);
        rst = 1'b0;
        check("R1 irq after second reset", 32'(irq), 0);
        rd_chk("R1 threshold after second reset", 10'h20C, 0);
        rd_chk("R1 priority after second reset", 10'h028, 0);
        rd_chk("R1 enable after second reset", 10'h204, 0);

        finish_run();
    end

endmodule